// File: doc/BRIEF.md
# PS/2 Host Port

This block connects a CPU register bus to a PS/2 keyboard or mouse line pair. Bytes the device sends are framed, checked for odd parity and queued in a small receive FIFO. Software reads the oldest queued byte without removing it and pops it with an explicit acknowledge write. A byte written by software is sent to the device with the host-to-device request sequence: clock held low, then data pulled low, then the device clocks the bits in.

The bus side is two 8-bit registers selected by one address bit: a data register (select 0) and a status/control register (select 1). Both PS/2 lines are open-drain. Each line has an input and an output enable; enable high pulls the line low. There is no back-pressure handshake at either edge. On the receive side the device cannot be stalled, so when the FIFO is full new bytes are lost. On the transmit side the busy status bit acts as the ready signal, and a data write made while busy is dropped.

Top module: `ps2_host_port`

## Requirements
- R1: A read with select 0 returns the byte at the FIFO head, or 0x00 when the FIFO is empty; reading does not remove the byte.
- R2: A write with select 1 removes the head byte from the FIFO; on an empty FIFO it has no effect.
- R3: A device frame is 11 bits sampled on falling clock edges: start 0, eight data bits least significant first, parity making the nine data+parity bits hold an odd number of ones, stop 1; good bytes enter the FIFO in arrival order.
- R4: A frame with correct start and stop but wrong parity is not queued and sets status bit 1; a status read (select 1) clears bit 1, except that a parity error arriving in the same cycle as the read leaves it set.
- R5: A frame with start bit 1 or stop bit 0 is not queued and does not set status bit 1.
- R6: The FIFO holds DEPTH bytes (default 8); bytes arriving while it is full are dropped and the stored ones are kept.
- R7: Status bit 0 is 1 exactly when the FIFO holds a byte; status bits 7:3 read 0.
- R8: A write with select 0 while idle starts sending that byte; status bit 2 is 1 from the next cycle until the transfer ends; a select 0 write while bit 2 is 1 is ignored.
- R9: A transfer holds the clock line low for INHIBIT_CYC cycles with data released, then releases clock and pulls data low (start), presents data bits LSB first, then odd parity, then releases data (stop) on successive device falling edges, and ends at the device's eleventh falling edge (acknowledge); both lines are released while idle.
- R10: A pop and a push landing in the same cycle leave exactly the new byte in place of the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register select: 0 data, 1 status/control |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; with select 1 it clears the parity flag |
| bus_wdata | input | 8 | Write data (byte to send for select 0) |
| bus_rdata | output | 8 | Read data for the selected register |
| ps2_clk_i | input | 1 | PS/2 clock line level |
| ps2_clk_oe | output | 1 | Pull PS/2 clock low when 1 |
| ps2_dat_i | input | 1 | PS/2 data line level |
| ps2_dat_oe | output | 1 | Pull PS/2 data low when 1 |

## Verification
A software acknowledge can pop the FIFO in the same cycle a newly received byte is pushed. The bench preloads one byte and starts a second frame. It sweeps the acknowledge write across a window of cycles around that frame's end, and in every case expects the head to be the new byte, one entry queued. The parity flag's clear-on-read can likewise meet a new parity error. The bench holds status reads asserted every cycle across the end of a bad-parity frame and expects exactly one of those reads to return bit 1 set.

// File: rtl/ps2_host_pkg.sv
package ps2_host_pkg;
  localparam int FRAME_LEN = 11;
  localparam logic REG_DATA = 1'b0;
  localparam logic REG_STAT = 1'b1;

  typedef enum logic [1:0] {TX_IDLE, TX_INHIBIT, TX_SHIFT} tx_state_e;

  // parity bit giving an odd count of ones over data plus parity
  function automatic logic odd_par(input logic [7:0] d);
    return ~(^d);
  endfunction
endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_in,   // [0] clock, [1] data
  output logic       dat_s,
  output logic       clk_fall
);
  logic [1:0] line_s;
  logic       clk_prev;

  genvar g;
  for (g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-2:0], line_in[g]};
    end
    assign line_s[g] = sh[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev <= 1'b1;
    else        clk_prev <= line_s[0];
  end

  assign clk_fall = clk_prev & ~line_s[0];
  assign dat_s    = line_s[1];
endmodule

// File: rtl/ps2_rx.sv
module ps2_rx
  import ps2_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       fall,
  input  logic       dat,
  output logic       byte_vld,
  output logic [7:0] byte_out,
  output logic       par_err
);
  logic [3:0] bit_cnt;
  logic [9:0] sr;   // [0] start, [8:1] data, [9] parity once full

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      sr       <= '0;
      byte_vld <= 1'b0;
      byte_out <= '0;
      par_err  <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      par_err  <= 1'b0;
      if (!en) begin
        bit_cnt <= '0;
      end else if (fall) begin
        if (bit_cnt == 4'(FRAME_LEN - 1)) begin
          bit_cnt <= '0;
          if (!sr[0] && dat) begin
            if (^sr[9:1]) begin
              byte_vld <= 1'b1;
              byte_out <= sr[8:1];
            end else begin
              par_err <= 1'b1;
            end
          end
        end else begin
          sr      <= {dat, sr[9:1]};
          bit_cnt <= bit_cnt + 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/ps2_fifo.sv
module ps2_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && (count != CW'(DEPTH));
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      unique case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ps2_tx.sv
module ps2_tx
  import ps2_host_pkg::*;
#(
  parameter int INHIBIT_CYC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       fall,
  output logic       busy,
  output logic       clk_oe,
  output logic       dat_oe
);
  localparam int CW = $clog2(INHIBIT_CYC + 1);

  tx_state_e     state;
  logic [CW-1:0] cnt;
  logic [3:0]    nfall;
  logic [10:0]   sr;   // bit on the wire is sr[0]

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      cnt   <= '0;
      nfall <= '0;
      sr    <= '1;
    end else begin
      unique case (state)
        TX_IDLE: if (start) begin
          state <= TX_INHIBIT;
          cnt   <= '0;
          sr    <= {1'b1, odd_par(tx_byte), tx_byte, 1'b0};
        end
        TX_INHIBIT: begin
          if (cnt == CW'(INHIBIT_CYC - 1)) begin
            state <= TX_SHIFT;
            nfall <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        TX_SHIFT: if (fall) begin
          if (nfall == 4'(FRAME_LEN - 1)) begin
            state <= TX_IDLE;   // acknowledge clock seen
          end else begin
            sr    <= {1'b1, sr[10:1]};
            nfall <= nfall + 4'd1;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign busy   = (state != TX_IDLE);
  assign clk_oe = (state == TX_INHIBIT);
  assign dat_oe = (state == TX_SHIFT) && !sr[0];
endmodule

// File: rtl/ps2_host_port.sv
module ps2_host_port
  import ps2_host_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int INHIBIT_CYC = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       ps2_clk_i,
  output logic       ps2_clk_oe,
  input  logic       ps2_dat_i,
  output logic       ps2_dat_oe
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             dat_s, clk_fall;
  logic             rx_vld, rx_perr;
  logic [7:0]       rx_byte, fifo_head;
  logic             fifo_empty;
  logic [CNT_W-1:0] fifo_cnt;
  logic             tx_busy;
  logic             perr_q;

  ps2_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in({ps2_dat_i, ps2_clk_i}),
    .dat_s(dat_s), .clk_fall(clk_fall)
  );

  ps2_rx u_rx (
    .clk(clk), .rst_n(rst_n), .en(!tx_busy), .fall(clk_fall), .dat(dat_s),
    .byte_vld(rx_vld), .byte_out(rx_byte), .par_err(rx_perr)
  );

  ps2_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(rx_vld), .din(rx_byte),
    .pop(bus_wr && bus_sel == REG_STAT),
    .head(fifo_head), .empty(fifo_empty), .count(fifo_cnt)
  );

  ps2_tx #(.INHIBIT_CYC(INHIBIT_CYC)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(bus_wr && bus_sel == REG_DATA),
    .tx_byte(bus_wdata), .fall(clk_fall),
    .busy(tx_busy), .clk_oe(ps2_clk_oe), .dat_oe(ps2_dat_oe)
  );

  // new error wins over a clearing read in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             perr_q <= 1'b0;
    else if (rx_perr)                       perr_q <= 1'b1;
    else if (bus_rd && bus_sel == REG_STAT) perr_q <= 1'b0;
  end

  always_comb begin
    if (bus_sel == REG_STAT) bus_rdata = {5'b0, tx_busy, perr_q, !fifo_empty};
    else                     bus_rdata = fifo_empty ? 8'h00 : fifo_head;
  end
endmodule

// File: rtl/ps2_host_port_chk.sv
module ps2_host_port_chk #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_sel,
  input logic                       bus_wr,
  input logic                       bus_rd,
  input logic [7:0]                 bus_rdata,
  input logic                       ps2_clk_oe,
  input logic                       ps2_dat_oe,
  input logic                       tx_busy,
  input logic                       perr,
  input logic                       rx_push,
  input logic [$clog2(DEPTH+1)-1:0] fifo_cnt
);
  localparam int CW = $clog2(DEPTH + 1);

  p_empty_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel && fifo_cnt == '0) |-> bus_rdata == 8'h00);

  p_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel && fifo_cnt != '0 && (!rx_push || fifo_cnt == CW'(DEPTH)))
    |=> fifo_cnt == $past(fifo_cnt) - CW'(1));

  p_perr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (perr && !(bus_rd && bus_sel)) |=> perr);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_sel && !tx_busy) |=> tx_busy);

  p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> (!ps2_clk_oe && !ps2_dat_oe));

  p_inhibit_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ps2_clk_oe |-> !ps2_dat_oe);

  p_push_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel && fifo_cnt != '0 && rx_push && fifo_cnt != CW'(DEPTH))
    |=> $stable(fifo_cnt));
endmodule

bind ps2_host_port ps2_host_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe),
  .tx_busy(tx_busy), .perr(perr_q), .rx_push(rx_vld), .fifo_cnt(fifo_cnt)
);

// File: tb/ps2_host_port_tb.sv
`timescale 1ns/1ps
module ps2_host_port_tb;
  localparam int DEPTH = 8;
  localparam int INH   = 64;
  localparam int H     = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       ps2_clk_oe, ps2_dat_oe;
  logic       dev_clk_low = 1'b0, dev_dat_low = 1'b0;
  wire        ps2_clk_i = ~(ps2_clk_oe | dev_clk_low);
  wire        ps2_dat_i = ~(ps2_dat_oe | dev_dat_low);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] q[$];

  always #2.5 clk = ~clk;

  ps2_host_port #(.DEPTH(DEPTH), .INHIBIT_CYC(INH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ps2_clk_i(ps2_clk_i), .ps2_clk_oe(ps2_clk_oe),
    .ps2_dat_i(ps2_dat_i), .ps2_dat_oe(ps2_dat_oe)
  );

  function automatic logic par_of(input logic [7:0] d);
    return ~(^d);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic sel, output logic [7:0] v);
    @(negedge clk);
    bus_sel = sel; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // expected status from the bench model
  function automatic logic [7:0] exp_stat(input bit busy, input bit perr);
    return {5'b0, busy, perr, q.size() != 0};
  endfunction

  task automatic check_regs(input string req, input bit perr);
    logic [7:0] v;
    bus_read(1'b0, v);
    chk(v == ((q.size() != 0) ? q[0] : 8'h00), req, v, (q.size() != 0) ? q[0] : 0);
    bus_read(1'b1, v);
    chk(v == exp_stat(1'b0, perr), req, v, exp_stat(1'b0, perr));
  endtask

  task automatic dev_send(input logic [7:0] b, input bit bad_par,
                          input bit bad_start, input bit bad_stop);
    logic [10:0] bits;
    bits = {~bad_stop, par_of(b) ^ bad_par, b, bad_start};
    for (int k = 0; k < 11; k++) begin
      @(negedge clk);
      dev_dat_low = ~bits[k];
      wait_cyc(H); dev_clk_low = 1'b1;
      wait_cyc(H); dev_clk_low = 1'b0;
      wait_cyc(H);
    end
    dev_dat_low = 1'b0;
    wait_cyc(8);
  endtask

  task automatic dev_recv(output logic [7:0] b, output logic par, output logic stp,
                          output int inh, output bit clean);
    logic [10:0] v;
    clean = 1'b1;
    v = '0;
    while (!ps2_clk_oe) @(negedge clk);
    inh = 0;
    while (ps2_clk_oe) begin
      inh++;
      if (ps2_dat_oe) clean = 1'b0;
      @(negedge clk);
    end
    if (ps2_dat_i !== 1'b0) clean = 1'b0;
    for (int k = 1; k <= 10; k++) begin
      wait_cyc(H); dev_clk_low = 1'b1;
      wait_cyc(H); v[k] = ps2_dat_i; dev_clk_low = 1'b0;
    end
    wait_cyc(H); dev_dat_low = 1'b1;
    wait_cyc(H); dev_clk_low = 1'b1;
    wait_cyc(H); dev_clk_low = 1'b0; dev_dat_low = 1'b0;
    b = v[8:1]; par = v[9]; stp = v[10];
  endtask

  task automatic send_good(input logic [7:0] b);
    dev_send(b, 1'b0, 1'b0, 1'b0);
    if (q.size() < DEPTH) q.push_back(b);
  endtask

  task automatic do_pop();
    bus_write(1'b1, 8'h00);
    if (q.size() != 0) void'(q.pop_front());
  endtask

  task automatic tx_one(input logic [7:0] b, input bit try_overwrite);
    logic [7:0] rb, v; logic rp, rs; int inh; bit clean;
    bus_write(1'b0, b);
    fork
      dev_recv(rb, rp, rs, inh, clean);
      begin
        bus_read(1'b1, v);
        chk(v[2] == 1'b1, "R8 busy after write", v, 8'h04);
        if (try_overwrite) bus_write(1'b0, ~b);
      end
    join
    chk(rb == b, "R9 byte LSB first", rb, b);
    chk(rp == par_of(b), "R9 odd parity", rp, par_of(b));
    chk(rs == 1'b1, "R9 stop released", rs, 1);
    chk(inh == INH, "R9 inhibit length", inh, INH);
    chk(clean, "R9 data released in inhibit, low at start", clean, 1);
    wait_cyc(8);
    bus_read(1'b1, v);
    chk(v[2] == 1'b0, "R8 busy cleared", v, 8'h00);
  endtask

  initial begin : main
    logic [7:0] v;
    int hits;
    void'($urandom(32'd2024));
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);

    // reset state
    check_regs("R7 reset", 1'b0);
    chk(!ps2_clk_oe && !ps2_dat_oe, "R9 idle release", {ps2_clk_oe, ps2_dat_oe}, 0);

    // pop on empty does nothing
    do_pop();
    check_regs("R2 empty pop", 1'b0);

    // directed frames, order, non-destructive read
    send_good(8'h00); send_good(8'hFF); send_good(8'h5A);
    bus_read(1'b0, v);
    check_regs("R1 read keeps head", 1'b0);
    for (int i = 0; i < 3; i++) begin
      check_regs("R3 arrival order", 1'b0);
      do_pop();
    end
    check_regs("R2 drained", 1'b0);

    // parity error flag and clear on read
    dev_send(8'h3C, 1'b1, 1'b0, 1'b0);
    bus_read(1'b1, v);
    chk(v == 8'h02, "R4 parity flag set", v, 8'h02);
    bus_read(1'b1, v);
    chk(v == 8'h00, "R4 parity flag cleared", v, 8'h00);

    // framing errors
    dev_send(8'h81, 1'b0, 1'b1, 1'b0);
    check_regs("R5 bad start dropped", 1'b0);
    dev_send(8'h42, 1'b0, 1'b0, 1'b1);
    check_regs("R5 bad stop dropped", 1'b0);
    send_good(8'hA7);
    check_regs("R3 after framing error", 1'b0);
    do_pop();

    // overflow
    for (int i = 0; i < DEPTH + 2; i++) send_good(8'h10 + 8'(i));
    bus_read(1'b1, v);
    chk(v == 8'h01, "R7 full status", v, 8'h01);
    for (int i = 0; i < DEPTH; i++) begin
      check_regs("R6 kept bytes", 1'b0);
      do_pop();
    end
    check_regs("R6 extra dropped", 1'b0);

    // constrained random receive traffic
    for (int i = 0; i < 40; i++) begin
      int r;
      r = $urandom % 10;
      if (r < 2) begin
        dev_send(8'($urandom), 1'b1, 1'b0, 1'b0);
        bus_read(1'b1, v);
        chk(v == exp_stat(1'b0, 1'b1), "R4 random parity", v, exp_stat(1'b0, 1'b1));
      end else if (r < 7) begin
        send_good(8'($urandom));
      end else begin
        do_pop();
      end
      check_regs("R3 random stream", 1'b0);
    end
    while (q.size() != 0) do_pop();

    // push and pop in the same cycle, swept over offsets
    for (int d = 0; d < 16; d++) begin
      logic [7:0] a, b;
      a = 8'($urandom); b = 8'($urandom);
      send_good(a);
      fork
        dev_send(b, 1'b0, 1'b0, 1'b0);
        begin wait_cyc(318 + d); bus_write(1'b1, 8'h00); end
      join
      bus_read(1'b0, v);
      chk(v == b, "R10 head after push+pop", v, b);
      bus_read(1'b1, v);
      chk(v == 8'h01, "R10 one entry", v, 8'h01);
      q.delete();
      do_pop();
    end

    // parity error against continuous clearing reads
    hits = 0;
    fork
      dev_send(8'h99, 1'b1, 1'b0, 1'b0);
      begin
        wait_cyc(310);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1;
        repeat (30) begin
          #1 if (bus_rdata[1]) hits++;
          @(negedge clk);
        end
        bus_rd = 1'b0;
      end
    join
    chk(hits == 1, "R4 set wins over clear", hits, 1);

    // transmit
    tx_one(8'hA5, 1'b1);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (ps2_clk_oe) begin
        chk(1'b0, "R8 ignored write started", 1, 0);
        break;
      end
    end
    chk(!ps2_clk_oe, "R8 no second transfer", ps2_clk_oe, 0);
    for (int i = 0; i < 3; i++) tx_one(8'($urandom), 1'b0);
    check_regs("R8 receive untouched by transmit", 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule